// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block watches that software keeps running. A 32-bit counter advances on every clock cycle while the watchdog is enabled. Software must service it by writing a two-word refresh key, and the second word must follow the first within a short limit. A valid refresh sets the counter back to zero. If the counter reaches the programmable timeout value, the block requests a system reset. In window mode, a refresh that comes before a programmable window-start value is treated as a fault.

The control, timeout and window-start registers are protected. They accept writes only during a limited period after software writes a two-word unlock key. Any wrong key word, or a late second word, is a fault. A fault can raise an interrupt first and then request the reset after a fixed delay. Low-power and debug mode inputs can pause the counter, each mode under its own enable bit. The reset request stays high until the block's own reset input clears it.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, control reads 0x01 (only the enable bit set), timeout reads the parameter DEF_TIMEOUT (1000 by default), window-start reads 0, and both irq and rst_req are low.
- R2: The addresses are 0 for control, 1 for timeout, 2 for window-start, 3 for the refresh key, 4 for the unlock key and 5 for the counter, which is read-only. The control bits are: bit0 enable, bit1 window mode, bit2 interrupt before reset, bit3 count in wait, bit4 count in stop, bit5 count in standby, bit6 count in debug. Addresses 0, 1, 2 and 5 are readable at any time.
- R3: Writing 0xA602 to the refresh address, then 0xB480 no more than 20 cycles later, clears the counter. The counter then reads 0 after the edge of the second write and goes up by one on each running cycle.
- R4: While enabled, a counter value at or above the timeout value is a fault. With timeout M and a refresh at edge E, the fault is seen at edge E+M+1.
- R5: Any write to the refresh address that is not the expected next key word is a fault. This covers a wrong second word, a lone second word, and a second word that arrives 21 or more cycles after the first. A write fault takes effect at the edge of that write.
- R6: The unlock key is 0xC520 followed by 0xD928 within 20 cycles. A wrong word at the unlock address is a fault, under the same rules as R5.
- R7: Writes to control, timeout and window-start take effect only during the 256 cycles after the edge that completes the unlock. At any other time they are ignored.
- R8: In window mode, a refresh that completes while the counter is below the window-start value is a fault and does not clear the counter.
- R9: With interrupt-before-reset set, a fault raises irq at the fault edge, and rst_req follows 128 cycles later. irq stays high.
- R10: With interrupt-before-reset clear, a fault raises rst_req at the fault edge, and irq stays low.
- R11: The counter holds while any active mode input (wait, stop, standby, debug) has its control count bit clear. It counts in a mode whose bit is set.
- R12: rst_req stays high until rst_n clears the block back to its R1 state. While the enable bit is clear, no fault has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and watchdog clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| in_wait | input | 1 | System is in wait mode |
| in_stop | input | 1 | System is in stop mode |
| in_standby | input | 1 | System is in standby mode |
| in_debug | input | 1 | System is halted for debug |
| irq | output | 1 | Interrupt raised ahead of the reset request |
| rst_req | output | 1 | System reset request |

## Verification
The assertions check the following on every cycle:
- rst_req and irq stay high once set.
- irq never rises after the reset request.
- The protected registers do not change while locked.
- A paused counter holds.
- A disabled watchdog never trips.

Only the bench scenarios can show the exact timing: the 20-cycle key limit at both edges, the 256-cycle unlock period at both edges, the 128-cycle interrupt lead, the timeout edge and the window rejection.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int KEY_GAP = 20,
  parameter int UNLOCK_WIN = 256,
  parameter int IRQ_DELAY = 128,
  parameter logic [31:0] DEF_TIMEOUT = 32'd1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        in_wait,
  input  logic        in_stop,
  input  logic        in_standby,
  input  logic        in_debug,
  output logic        irq,
  output logic        rst_req
);

  localparam logic [2:0] A_CTRL = 3'd0, A_TMO = 3'd1, A_WIN = 3'd2,
                         A_REFR = 3'd3, A_UNLK = 3'd4, A_CNT = 3'd5;
  localparam int GW = $clog2(KEY_GAP + 2);
  localparam int UW = $clog2(UNLOCK_WIN + 1);
  localparam int DW = $clog2(IRQ_DELAY + 1);

  logic [6:0]    ctrl;
  logic [31:0]   timeout, win_start, cnt;
  logic [UW-1:0] unlk_cnt;
  logic [DW-1:0] dly;
  logic [1:0]    seq_ok, seq_bad;

  wire unlocked = unlk_cnt != '0;
  wire tripped  = irq | rst_req;
  wire paused   = (in_wait & ~ctrl[3]) | (in_stop & ~ctrl[4]) |
                  (in_standby & ~ctrl[5]) | (in_debug & ~ctrl[6]);
  wire early    = seq_ok[0] & ctrl[1] & (cnt < win_start);
  wire fault    = ctrl[0] & ~tripped & ((|seq_bad) | early | (cnt >= timeout));
  wire cfg_wr   = wr_en & unlocked;

  for (genvar k = 0; k < 2; k++) begin : g_key
    localparam logic [31:0] W1 = (k == 0) ? 32'h0000_A602 : 32'h0000_C520;
    localparam logic [31:0] W2 = (k == 0) ? 32'h0000_B480 : 32'h0000_D928;
    logic          armed;
    logic [GW-1:0] gap;
    wire hit = wr_en && (wr_addr == ((k == 0) ? A_REFR : A_UNLK));
    assign seq_ok[k]  = hit && armed && (wr_data == W2) && (gap <= GW'(KEY_GAP));
    assign seq_bad[k] = hit && !seq_ok[k] && (armed || (wr_data != W1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed <= 1'b0;
        gap   <= '0;
      end else if (hit) begin
        armed <= !armed && (wr_data == W1);
        gap   <= GW'(1);
      end else if (armed && gap <= GW'(KEY_GAP)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= 7'h01;
      timeout   <= DEF_TIMEOUT;
      win_start <= '0;
    end else if (cfg_wr) begin
      if (wr_addr == A_CTRL) ctrl      <= wr_data[6:0];
      if (wr_addr == A_TMO)  timeout   <= wr_data;
      if (wr_addr == A_WIN)  win_start <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          unlk_cnt <= '0;
    else if (seq_ok[1])  unlk_cnt <= UW'(UNLOCK_WIN);
    else if (unlocked)   unlk_cnt <= unlk_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt <= '0;
    else if (seq_ok[0] && !early)                cnt <= '0;
    else if (ctrl[0] && !paused && !tripped && cnt != '1) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
      dly     <= '0;
    end else if (fault) begin
      if (ctrl[2]) begin
        irq <= 1'b1;
        dly <= DW'(IRQ_DELAY - 1);
      end else begin
        rst_req <= 1'b1;
      end
    end else if (irq && !rst_req) begin
      if (dly == '0) rst_req <= 1'b1;
      else           dly <= dly - 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {25'd0, ctrl};
      A_TMO:   rd_data = timeout;
      A_WIN:   rd_data = win_start;
      A_CNT:   rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);  // R12
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq);  // R9
  AST_IRQ_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !rst_req);  // R9
  AST_LOCKED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(ctrl) && $stable(timeout) && $stable(win_start)));  // R7
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !seq_ok[0]) |=> $stable(cnt));  // R11
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !tripped) |=> (!irq && !rst_req));  // R12

endmodule

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic in_wait = 0, in_stop = 0, in_standby = 0, in_debug = 0;
  logic irq, rst_req;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  int    q_cyc[$];
  bit    q_irq[$], q_rst[$];
  string q_tag[$];

  keyed_wdog uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
                  .in_wait, .in_stop, .in_standby, .in_debug, .irq, .rst_req);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int c, input bit i, input bit r, input string tag);
    q_cyc.push_back(c); q_irq.push_back(i); q_rst.push_back(r); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      check({q_tag[0], " irq"}, {31'd0, irq}, {31'd0, q_irq[0]});
      check({q_tag[0], " rst_req"}, {31'd0, rst_req}, {31'd0, q_rst[0]});
      void'(q_cyc.pop_front()); void'(q_irq.pop_front());
      void'(q_rst.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    while (q_cyc.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset();
    drain();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic unlock();
    wr(3'd4, 32'hC520); wr(3'd4, 32'hD928);
  endtask

  task automatic refresh(output int e);
    wr(3'd3, 32'hA602); wr(3'd3, 32'hB480); e = cyc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int e, e2;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 reset state
    rd(3'd0, d); check("R1 ctrl", d, 32'h01);
    rd(3'd1, d); check("R1 timeout", d, 32'd1000);
    rd(3'd2, d); check("R2 window", d, 32'd0);
    check("R1 outputs", {30'd0, irq, rst_req}, 32'd0);

    // R7 locked write ignored
    wr(3'd1, 32'd50);
    rd(3'd1, d); check("R7 locked write", d, 32'd1000);

    // R3 R4 R10 R12 timeout path
    unlock(); wr(3'd1, 32'd60);
    rd(3'd1, d); check("R7 unlocked write", d, 32'd60);
    refresh(e);
    rd(3'd5, d); check("R3 counter cleared", d, 32'd0);
    wait_cyc(e + 5);
    rd(3'd5, d); check("R3 counter runs", d, 32'd5);
    expect_ev(e + 60, 0, 0, "R4 before timeout");
    expect_ev(e + 61, 0, 1, "R10 direct reset");
    expect_ev(e + 120, 0, 1, "R12 reset held");
    do_reset();
    rd(3'd1, d); check("R12 defaults restored", d, 32'd1000);
    check("R12 outputs cleared", {30'd0, irq, rst_req}, 32'd0);

    // R5 gap boundary
    wr(3'd3, 32'hA602); e = cyc;
    wait_cyc(e + 19); wr(3'd3, 32'hB480);
    check("R3 gap 20 accepted", {31'd0, rst_req}, 32'd0);
    rd(3'd5, d); check("R3 gap 20 clears", d, 32'd0);
    wr(3'd3, 32'hA602); e2 = cyc;
    wait_cyc(e2 + 20); wr(3'd3, 32'hB480);
    check("R5 gap 21 fault", {31'd0, rst_req}, 32'd1);
    do_reset();

    wr(3'd3, 32'hA602); wr(3'd3, 32'h1234);
    check("R5 wrong second word", {31'd0, rst_req}, 32'd1);
    do_reset();
    wr(3'd3, 32'hB480);
    check("R5 lone second word", {31'd0, rst_req}, 32'd1);
    do_reset();

    // R6 bad unlock
    wr(3'd4, 32'hC520); wr(3'd4, 32'hD929);
    check("R6 bad unlock", {31'd0, rst_req}, 32'd1);
    do_reset();

    // R7 unlock period edges
    unlock(); e = cyc;
    wait_cyc(e + 255); wr(3'd2, 32'd7);
    rd(3'd2, d); check("R7 last unlocked cycle", d, 32'd7);
    wr(3'd2, 32'd9);
    rd(3'd2, d); check("R7 relocked", d, 32'd7);
    do_reset();

    // R8 window mode
    unlock(); wr(3'd2, 32'd30); wr(3'd0, 32'h03);
    refresh(e);
    check("R8 early refresh fault", {31'd0, rst_req}, 32'd1);
    do_reset();
    unlock(); wr(3'd2, 32'd30); wr(3'd0, 32'h03);
    wait_cyc(cyc + 40);
    refresh(e);
    check("R8 in-window ok", {31'd0, rst_req}, 32'd0);
    rd(3'd5, d); check("R8 in-window clears", d, 32'd0);
    refresh(e);
    check("R8 second early fault", {31'd0, rst_req}, 32'd1);
    do_reset();

    // R9 interrupt first
    unlock(); wr(3'd1, 32'd40); wr(3'd0, 32'h05);
    refresh(e);
    expect_ev(e + 40, 0, 0, "R9 quiet");
    expect_ev(e + 41, 1, 0, "R9 irq first");
    expect_ev(e + 168, 1, 0, "R9 delay not done");
    expect_ev(e + 169, 1, 1, "R9 reset after delay");
    do_reset();

    // R11 pause
    unlock(); wr(3'd0, 32'h41);
    refresh(e);
    in_wait = 1'b1;
    wait_cyc(e + 10);
    rd(3'd5, d); check("R11 wait pauses", d, 32'd0);
    in_wait = 1'b0; in_debug = 1'b1;
    wait_cyc(e + 15);
    rd(3'd5, d); check("R11 debug counts", d, 32'd5);
    in_debug = 1'b0; in_stop = 1'b1;
    wait_cyc(e + 20);
    rd(3'd5, d); check("R11 stop pauses", d, 32'd5);
    in_stop = 1'b0;
    do_reset();

    // R12 disabled
    unlock(); wr(3'd1, 32'd20); wr(3'd0, 32'h00);
    wait_cyc(cyc + 60);
    wr(3'd3, 32'h1234);
    check("R12 disabled no reset", {30'd0, irq, rst_req}, 32'd0);
    drain();
    finish_run();
  end
endmodule